// File: doc/BRIEF.md
# Interrupt Flag Aggregator

This block turns event strobes and level conditions from a bus communication controller into sticky interrupt flags. It then merges them into a small set of registered interrupt request lines. Five kinds of source feed it:
- two receive FIFOs, each compared against a programmable watermark;
- a bus wakeup strobe;
- a parameterised set of protocol event strobes;
- a set of host-interface error strobes;
- per-message-buffer request lines, each with a direction bit that assigns it to the receive group or the transmit group.

Software reaches the block through a single-cycle write port and a combinational read port. Through them it sets enables, programs watermarks, reads the flags, and clears flags by writing ones.

Enables work at two levels for protocol events. Each protocol source has its own enable bit, and the combined protocol request also needs a group enable. All host-interface error flags share a single common enable. The FIFO and wakeup requests each have one enable. Message-buffer requests are not latched: the combined receive and transmit requests follow the live buffer lines, gated by a group enable.

Top module: `irq_flag_aggregator`

## Requirements
- R1: A FIFO almost-full flag is set in a cycle in which that FIFO's fill level is strictly greater than its watermark. A level equal to the watermark does not set it. The watermarks sit at addresses 5 (FIFO A) and 6 (FIFO B). The flags are bits 0 (A) and 1 (B) of address 1. The FIFO requests are enabled by bits 0 (A) and 1 (B) of the group-enable register at address 0.
- R2: A wakeup strobe sets the wakeup flag, bit 2 of address 1. `irq_wakeup` is active only when group-enable bit 2 is set.
- R3: Each protocol strobe sets its own flag at address 2, with bit i for source i. `irq_prot` is active only when a flag is set whose individual enable is set, and group-enable bit 3 is set. The individual enables are at address 3, bit i.
- R4: Each host-interface error strobe sets its own flag at address 4. `irq_herr` is active when any of these flags is set and the single common enable, group-enable bit 4, is set.
- R5: `irq_rxbuf` is active when at least one buffer has its request high and its direction bit 0, and group-enable bit 5 is set.
- R6: `irq_txbuf` is active when at least one buffer has its request high and its direction bit 1, and group-enable bit 6 is set.
- R7: Flags are sticky. Writing 1 to a flag's bit at its address clears it. Writing 0 leaves it unchanged.
- R8: When a set event and a clear of the same flag fall in one cycle, the flag ends up set.
- R9: Every request output is registered. It changes one clock after its condition changes.
- R10: After reset:
  - all flags, enables and request outputs are 0;
  - both watermarks read as all ones, so no almost-full flag can set.
- R11: The read port returns the addressed register, zero-extended, in the same cycle. Address 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_a | input | FILL_W | Fill level of receive FIFO A |
| fill_b | input | FILL_W | Fill level of receive FIFO B |
| wakeup_evt | input | 1 | Wakeup symbol received strobe |
| prot_evt | input | NUM_PROT | Protocol event strobes |
| herr_evt | input | NUM_HERR | Host-interface error strobes |
| mb_irq | input | NUM_MB | Per-buffer interrupt request lines |
| mb_is_tx | input | NUM_MB | Per-buffer direction, 1 = transmit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Register read data |
| irq_fifo_a | output | 1 | FIFO A almost-full request |
| irq_fifo_b | output | 1 | FIFO B almost-full request |
| irq_wakeup | output | 1 | Wakeup request |
| irq_prot | output | 1 | Combined protocol request |
| irq_herr | output | 1 | Combined host-interface error request |
| irq_rxbuf | output | 1 | Combined receive-buffer request |
| irq_txbuf | output | 1 | Combined transmit-buffer request |

## Verification
Several properties are checked on every clock:
- flags hold until cleared;
- a set event beats a simultaneous clear;
- a fill level above the watermark always sets its flag, and a level at or below it never does;
- each request follows its enabled condition one clock later;
- a disabled wakeup group never raises a request.

The distinction between individual and group enables, the direction split of buffer requests, the write-zero case and the exact register contents on the read port are shown only by the bench's scenarios. There, a behavioural model is compared against every output on every clock.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int ADDR_W   = 3;
   localparam int NUM_FIFO = 2;

   localparam logic [ADDR_W-1:0] ADDR_GCTRL = 3'd0;
   localparam logic [ADDR_W-1:0] ADDR_GFLAG = 3'd1;
   localparam logic [ADDR_W-1:0] ADDR_PFLAG = 3'd2;
   localparam logic [ADDR_W-1:0] ADDR_PEN   = 3'd3;
   localparam logic [ADDR_W-1:0] ADDR_HFLAG = 3'd4;
   localparam logic [ADDR_W-1:0] ADDR_WM_A  = 3'd5;
   localparam logic [ADDR_W-1:0] ADDR_WM_B  = 3'd6;

   typedef enum int {
      GE_FIFO_A = 0,
      GE_FIFO_B = 1,
      GE_WAKE   = 2,
      GE_PROT   = 3,
      GE_HERR   = 4,
      GE_RXBUF  = 5,
      GE_TXBUF  = 6
   } gen_bit_e;
   localparam int NUM_GEN = 7;

   localparam int GF_FIFO_A = 0;
   localparam int GF_FIFO_B = 1;
   localparam int GF_WAKE   = 2;
   localparam int NUM_GFLAG = 3;
endpackage

// File: rtl/sticky_flag_bank.sv
module sticky_flag_bank #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] flags_o
);
   logic [WIDTH-1:0] flags_q;

   if (WIDTH < 1) begin : g_bad_width
      $error("sticky_flag_bank: WIDTH must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_i) | set_i;
   end

   assign flags_o = flags_q;

   // R7: a flag not being cleared keeps its value
   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags_q & ~clr_i) != '0) |=>
      ((flags_q & $past(flags_q & ~clr_i)) == $past(flags_q & ~clr_i)));

   // R8: a set event is never lost to a clear in the same cycle
   assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/fill_level_monitor.sv
module fill_level_monitor #(
   parameter int FILL_W = 8
) (
   input  logic [FILL_W-1:0] fill_i,
   input  logic [FILL_W-1:0] wm_i,
   output logic              over_o
);
   if (FILL_W < 1) begin : g_bad_fill
      $error("fill_level_monitor: FILL_W must be at least 1");
   end

   assign over_o = (fill_i > wm_i);
endmodule

// File: rtl/irq_group_combine.sv
module irq_group_combine #(
   parameter int WIDTH      = 8,
   parameter bit PER_SRC_EN = 1'b1,
   parameter int EN_W       = PER_SRC_EN ? WIDTH : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] src_i,
   input  logic [EN_W-1:0]  en_i,
   input  logic             grp_en_i,
   output logic             req_o
);
   logic hit;
   logic req_q;

   if (PER_SRC_EN) begin : g_per_source
      if (EN_W != WIDTH) begin : g_bad_en
         $error("irq_group_combine: EN_W must equal WIDTH");
      end
      assign hit = |(src_i & en_i);
   end else begin : g_common
      if (EN_W != 1) begin : g_bad_en
         $error("irq_group_combine: EN_W must be 1 for a common enable");
      end
      assign hit = (|src_i) & en_i[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= hit & grp_en_i;
   end

   assign req_o = req_q;

   // R9: request rises one clock after its condition
   assert_req_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && grp_en_i) |=> req_o);
   // R9: request drops one clock after its condition ends
   assert_req_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && grp_en_i) |=> !req_o);
endmodule

// File: rtl/irq_flag_aggregator.sv
module irq_flag_aggregator
   import irq_agg_pkg::*;
#(
   parameter int FILL_W   = 8,
   parameter int NUM_PROT = 25,
   parameter int NUM_HERR = 16,
   parameter int NUM_MB   = 8,
   parameter int DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [FILL_W-1:0]   fill_a,
   input  logic [FILL_W-1:0]   fill_b,
   input  logic                wakeup_evt,
   input  logic [NUM_PROT-1:0] prot_evt,
   input  logic [NUM_HERR-1:0] herr_evt,
   input  logic [NUM_MB-1:0]   mb_irq,
   input  logic [NUM_MB-1:0]   mb_is_tx,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   output logic                irq_fifo_a,
   output logic                irq_fifo_b,
   output logic                irq_wakeup,
   output logic                irq_prot,
   output logic                irq_herr,
   output logic                irq_rxbuf,
   output logic                irq_txbuf
);
   localparam logic [FILL_W-1:0] WM_RESET = '1;

   if (NUM_PROT > DATA_W || NUM_HERR > DATA_W || FILL_W > DATA_W || NUM_GEN > DATA_W)
   begin : g_bad_data_w
      $error("irq_flag_aggregator: a register is wider than DATA_W");
   end
   if (NUM_MB < 1 || NUM_PROT < 1 || NUM_HERR < 1) begin : g_bad_count
      $error("irq_flag_aggregator: source counts must be at least 1");
   end

   // ---------------- configuration registers ----------------
   logic [NUM_GEN-1:0]  gen_q;
   logic [NUM_PROT-1:0] pen_q;
   logic [FILL_W-1:0]   wm_q [NUM_FIFO];
   logic                unused_wr_hi;

   assign unused_wr_hi = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_q <= '0;
         pen_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_GCTRL) gen_q <= wr_data[NUM_GEN-1:0];
         if (wr_addr == ADDR_PEN)   pen_q <= wr_data[NUM_PROT-1:0];
      end
   end

   // ---------------- watermark compare per FIFO ----------------
   logic [FILL_W-1:0]   fill_arr [NUM_FIFO];
   logic [NUM_FIFO-1:0] over;

   assign fill_arr[0] = fill_a;
   assign fill_arr[1] = fill_b;

   for (genvar g = 0; g < NUM_FIFO; g++) begin : g_fifo
      localparam logic [ADDR_W-1:0] WM_ADDR = ADDR_WM_A + ADDR_W'(g);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              wm_q[g] <= WM_RESET;
         else if (wr_en && wr_addr == WM_ADDR)    wm_q[g] <= wr_data[FILL_W-1:0];
      end

      fill_level_monitor #(.FILL_W(FILL_W)) u_mon (
         .fill_i (fill_arr[g]),
         .wm_i   (wm_q[g]),
         .over_o (over[g])
      );
   end

   // ---------------- sticky flags ----------------
   logic [NUM_GFLAG-1:0] gflag, gflag_set, gflag_clr;
   logic [NUM_PROT-1:0]  pflag, pflag_clr;
   logic [NUM_HERR-1:0]  hflag, hflag_clr;

   assign gflag_set = {wakeup_evt, over[1], over[0]};
   assign gflag_clr = (wr_en && wr_addr == ADDR_GFLAG) ? wr_data[NUM_GFLAG-1:0] : '0;
   assign pflag_clr = (wr_en && wr_addr == ADDR_PFLAG) ? wr_data[NUM_PROT-1:0]  : '0;
   assign hflag_clr = (wr_en && wr_addr == ADDR_HFLAG) ? wr_data[NUM_HERR-1:0]  : '0;

   sticky_flag_bank #(.WIDTH(NUM_GFLAG)) u_gflags (
      .clk (clk), .rst_n (rst_n), .set_i (gflag_set), .clr_i (gflag_clr), .flags_o (gflag)
   );
   sticky_flag_bank #(.WIDTH(NUM_PROT)) u_pflags (
      .clk (clk), .rst_n (rst_n), .set_i (prot_evt), .clr_i (pflag_clr), .flags_o (pflag)
   );
   sticky_flag_bank #(.WIDTH(NUM_HERR)) u_hflags (
      .clk (clk), .rst_n (rst_n), .set_i (herr_evt), .clr_i (hflag_clr), .flags_o (hflag)
   );

   // ---------------- combined requests ----------------
   irq_group_combine #(.WIDTH(1), .PER_SRC_EN(1'b0)) u_req_fa (
      .clk (clk), .rst_n (rst_n), .src_i (gflag[GF_FIFO_A]), .en_i (gen_q[GE_FIFO_A]),
      .grp_en_i (1'b1), .req_o (irq_fifo_a)
   );
   irq_group_combine #(.WIDTH(1), .PER_SRC_EN(1'b0)) u_req_fb (
      .clk (clk), .rst_n (rst_n), .src_i (gflag[GF_FIFO_B]), .en_i (gen_q[GE_FIFO_B]),
      .grp_en_i (1'b1), .req_o (irq_fifo_b)
   );
   irq_group_combine #(.WIDTH(1), .PER_SRC_EN(1'b0)) u_req_wk (
      .clk (clk), .rst_n (rst_n), .src_i (gflag[GF_WAKE]), .en_i (gen_q[GE_WAKE]),
      .grp_en_i (1'b1), .req_o (irq_wakeup)
   );
   irq_group_combine #(.WIDTH(NUM_PROT), .PER_SRC_EN(1'b1)) u_req_prot (
      .clk (clk), .rst_n (rst_n), .src_i (pflag), .en_i (pen_q),
      .grp_en_i (gen_q[GE_PROT]), .req_o (irq_prot)
   );
   irq_group_combine #(.WIDTH(NUM_HERR), .PER_SRC_EN(1'b0)) u_req_herr (
      .clk (clk), .rst_n (rst_n), .src_i (hflag), .en_i (gen_q[GE_HERR]),
      .grp_en_i (1'b1), .req_o (irq_herr)
   );

   logic [NUM_MB-1:0] mb_rx_sel, mb_tx_sel;
   for (genvar b = 0; b < NUM_MB; b++) begin : g_mb_dir
      assign mb_rx_sel[b] = ~mb_is_tx[b];
      assign mb_tx_sel[b] =  mb_is_tx[b];
   end

   irq_group_combine #(.WIDTH(NUM_MB), .PER_SRC_EN(1'b1)) u_req_rx (
      .clk (clk), .rst_n (rst_n), .src_i (mb_irq), .en_i (mb_rx_sel),
      .grp_en_i (gen_q[GE_RXBUF]), .req_o (irq_rxbuf)
   );
   irq_group_combine #(.WIDTH(NUM_MB), .PER_SRC_EN(1'b1)) u_req_tx (
      .clk (clk), .rst_n (rst_n), .src_i (mb_irq), .en_i (mb_tx_sel),
      .grp_en_i (gen_q[GE_TXBUF]), .req_o (irq_txbuf)
   );

   // ---------------- read port ----------------
   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_GCTRL: rd_data[NUM_GEN-1:0]   = gen_q;
         ADDR_GFLAG: rd_data[NUM_GFLAG-1:0] = gflag;
         ADDR_PFLAG: rd_data[NUM_PROT-1:0]  = pflag;
         ADDR_PEN:   rd_data[NUM_PROT-1:0]  = pen_q;
         ADDR_HFLAG: rd_data[NUM_HERR-1:0]  = hflag;
         ADDR_WM_A:  rd_data[FILL_W-1:0]    = wm_q[0];
         ADDR_WM_B:  rd_data[FILL_W-1:0]    = wm_q[1];
         default:    rd_data = '0;
      endcase
   end

   // R1: level above watermark always sets the flag
   assert_fifo_a_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_a > wm_q[0]) |=> gflag[GF_FIFO_A]);
   // R1: level at or below watermark never sets a clear flag
   assert_fifo_a_equal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!gflag[GF_FIFO_A] && fill_a <= wm_q[0]) |=> !gflag[GF_FIFO_A]);
   assert_fifo_b_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_b > wm_q[1]) |=> gflag[GF_FIFO_B]);
   // R2: wakeup request stays low while its enable is off
   assert_wake_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_q[GE_WAKE] |=> !irq_wakeup);
endmodule

// File: tb/test_irq_flag_aggregator.sv
`timescale 1ns/1ps
module test_irq_flag_aggregator;
   localparam int FILL_W = 8, NUM_PROT = 25, NUM_HERR = 16, NUM_MB = 8, DATA_W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [FILL_W-1:0]   fill_a = '0, fill_b = '0;
   logic                wakeup_evt = 1'b0;
   logic [NUM_PROT-1:0] prot_evt = '0;
   logic [NUM_HERR-1:0] herr_evt = '0;
   logic [NUM_MB-1:0]   mb_irq = '0, mb_is_tx = '0;
   logic                wr_en = 1'b0;
   logic [2:0]          wr_addr = '0, rd_addr = '0;
   logic [DATA_W-1:0]   wr_data = '0;
   logic [DATA_W-1:0]   rd_data;
   logic irq_fifo_a, irq_fifo_b, irq_wakeup, irq_prot, irq_herr, irq_rxbuf, irq_txbuf;

   always #2 clk = ~clk;

   irq_flag_aggregator #(.FILL_W(FILL_W), .NUM_PROT(NUM_PROT), .NUM_HERR(NUM_HERR),
      .NUM_MB(NUM_MB), .DATA_W(DATA_W)) i_irq_flag_aggregator (
      .clk (clk), .rst_n (rst_n), .fill_a (fill_a), .fill_b (fill_b),
      .wakeup_evt (wakeup_evt), .prot_evt (prot_evt), .herr_evt (herr_evt),
      .mb_irq (mb_irq), .mb_is_tx (mb_is_tx), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
      .irq_fifo_a (irq_fifo_a), .irq_fifo_b (irq_fifo_b), .irq_wakeup (irq_wakeup),
      .irq_prot (irq_prot), .irq_herr (irq_herr), .irq_rxbuf (irq_rxbuf),
      .irq_txbuf (irq_txbuf)
   );

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [DATA_W-1:0] got,
                      input logic [DATA_W-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [6:0]  m_en;
   logic [24:0] m_pen, m_pf;
   logic [15:0] m_hf;
   logic [2:0]  m_gf;
   logic [7:0]  m_wa, m_wb;
   logic [6:0]  m_irq;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = '0; m_pen = '0; m_pf = '0; m_hf = '0; m_gf = '0;
         m_wa = 8'hFF; m_wb = 8'hFF; m_irq = '0;
      end else begin
         m_irq[0] = m_en[0] && m_gf[0];
         m_irq[1] = m_en[1] && m_gf[1];
         m_irq[2] = m_en[2] && m_gf[2];
         m_irq[3] = m_en[3] && ((m_pf & m_pen) != 0);
         m_irq[4] = m_en[4] && (m_hf != 0);
         m_irq[5] = m_en[5] && ((mb_irq & ~mb_is_tx) != 0);
         m_irq[6] = m_en[6] && ((mb_irq & mb_is_tx) != 0);
         if (wr_en && wr_addr == 3'd1) m_gf = m_gf & ~wr_data[2:0];
         if (wr_en && wr_addr == 3'd2) m_pf = m_pf & ~wr_data[24:0];
         if (wr_en && wr_addr == 3'd4) m_hf = m_hf & ~wr_data[15:0];
         if (fill_a > m_wa) m_gf[0] = 1'b1;
         if (fill_b > m_wb) m_gf[1] = 1'b1;
         if (wakeup_evt)    m_gf[2] = 1'b1;
         m_pf = m_pf | prot_evt;
         m_hf = m_hf | herr_evt;
         if (wr_en && wr_addr == 3'd0) m_en  = wr_data[6:0];
         if (wr_en && wr_addr == 3'd3) m_pen = wr_data[24:0];
         if (wr_en && wr_addr == 3'd5) m_wa  = wr_data[7:0];
         if (wr_en && wr_addr == 3'd6) m_wb  = wr_data[7:0];
      end
   end

   function automatic logic [DATA_W-1:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return {25'd0, m_en};
         3'd1: return {29'd0, m_gf};
         3'd2: return {7'd0, m_pf};
         3'd3: return {7'd0, m_pen};
         3'd4: return {16'd0, m_hf};
         3'd5: return {24'd0, m_wa};
         3'd6: return {24'd0, m_wb};
         default: return '0;
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1 irq_fifo_a", {31'd0, irq_fifo_a}, {31'd0, m_irq[0]});
         chk("R1 irq_fifo_b", {31'd0, irq_fifo_b}, {31'd0, m_irq[1]});
         chk("R2 irq_wakeup", {31'd0, irq_wakeup}, {31'd0, m_irq[2]});
         chk("R3 irq_prot",   {31'd0, irq_prot},   {31'd0, m_irq[3]});
         chk("R4 irq_herr",   {31'd0, irq_herr},   {31'd0, m_irq[4]});
         chk("R5 irq_rxbuf",  {31'd0, irq_rxbuf},  {31'd0, m_irq[5]});
         chk("R6 irq_txbuf",  {31'd0, irq_txbuf},  {31'd0, m_irq[6]});
         chk("R11 rd_data",   rd_data, m_read(rd_addr));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         wr_en = 1'b0;
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
   endtask

   task automatic peek(input logic [2:0] a, input logic [DATA_W-1:0] exp, input string tag);
      rd_addr = a;
      #0.5;
      chk(tag, rd_data, exp);
   endtask

   // ---------------- watchdog ----------------
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      // R10 reset state
      peek(3'd5, 32'hFF, "R10 watermark A reset");
      peek(3'd6, 32'hFF, "R10 watermark B reset");
      peek(3'd0, 32'h0,  "R10 enables reset");
      chk("R10 outputs reset", {25'd0, irq_fifo_a, irq_fifo_b, irq_wakeup, irq_prot,
          irq_herr, irq_rxbuf, irq_txbuf}, 32'h0);
      fill_a = 8'd200; tick(2);
      peek(3'd1, 32'h0, "R10 max watermark blocks flag");
      fill_a = 8'd0;

      // R1 equal does not set, above sets
      wr(3'd5, 32'd10);
      fill_a = 8'd10; tick(3);
      peek(3'd1, 32'h0, "R1 equal to watermark");
      fill_a = 8'd11; tick();
      fill_a = 8'd0;
      peek(3'd1, 32'h1, "R1 above watermark");
      wr(3'd0, 32'h1); tick();
      chk("R9 fifo A request after enable", {31'd0, irq_fifo_a}, 32'h1);
      wr(3'd0, 32'h0);
      chk("R9 request holds one clock", {31'd0, irq_fifo_a}, 32'h1);
      tick();
      chk("R9 request dropped", {31'd0, irq_fifo_a}, 32'h0);

      // R7 write zero keeps, write one clears
      wr(3'd1, 32'h0);
      peek(3'd1, 32'h1, "R7 write zero no effect");
      wr(3'd1, 32'h1);
      peek(3'd1, 32'h0, "R7 write one clears");

      // R8 event wins over clear
      fill_a = 8'd11; wr(3'd1, 32'h1); fill_a = 8'd0;
      peek(3'd1, 32'h1, "R8 set beats clear");
      wr(3'd1, 32'h1);

      // FIFO B
      wr(3'd6, 32'd200);
      fill_b = 8'd200; tick(2);
      peek(3'd1, 32'h0, "R1 fifo B equal");
      fill_b = 8'd201; tick(); fill_b = 8'd0;
      peek(3'd1, 32'h2, "R1 fifo B above");
      wr(3'd1, 32'h2);

      // R2 wakeup
      wakeup_evt = 1'b1; tick(); wakeup_evt = 1'b0;
      peek(3'd1, 32'h4, "R2 wakeup flag");
      tick(2);
      chk("R2 wakeup disabled", {31'd0, irq_wakeup}, 32'h0);
      wr(3'd0, 32'h4); tick();
      chk("R2 wakeup enabled", {31'd0, irq_wakeup}, 32'h1);
      wr(3'd1, 32'h4);

      // R3 protocol, two-level enable
      wr(3'd3, 32'h10000F0);
      prot_evt = 25'h1; tick(); prot_evt = '0;
      peek(3'd2, 32'h1, "R3 protocol flag");
      wr(3'd0, 32'h8); tick(2);
      chk("R3 unenabled source masked", {31'd0, irq_prot}, 32'h0);
      prot_evt = 25'h1000000; tick(); prot_evt = '0; tick();
      chk("R3 top source enabled", {31'd0, irq_prot}, 32'h1);
      wr(3'd0, 32'h0); tick();
      chk("R3 group enable off", {31'd0, irq_prot}, 32'h0);
      wr(3'd2, 32'h1FFFFFF);
      peek(3'd2, 32'h0, "R7 protocol clear");

      // R4 host-interface errors, common enable
      herr_evt = 16'h8000; tick(); herr_evt = '0; tick();
      chk("R4 common enable off", {31'd0, irq_herr}, 32'h0);
      wr(3'd0, 32'h10); tick();
      chk("R4 common enable on", {31'd0, irq_herr}, 32'h1);
      wr(3'd4, 32'hFFFF); tick();
      chk("R4 cleared", {31'd0, irq_herr}, 32'h0);

      // R5 / R6 buffer direction
      wr(3'd0, 32'h60);
      mb_irq = 8'h01; mb_is_tx = 8'h00; tick(2);
      chk("R5 receive buffer", {30'd0, irq_rxbuf, irq_txbuf}, 32'h2);
      mb_is_tx = 8'h01; tick(2);
      chk("R6 transmit buffer", {30'd0, irq_rxbuf, irq_txbuf}, 32'h1);
      mb_irq = 8'h81; tick(2);
      chk("R5 R6 both groups", {30'd0, irq_rxbuf, irq_txbuf}, 32'h3);
      wr(3'd0, 32'h20); tick();
      chk("R6 group enable off", {30'd0, irq_rxbuf, irq_txbuf}, 32'h2);
      mb_irq = 8'h00; tick(2);
      chk("R5 no request", {30'd0, irq_rxbuf, irq_txbuf}, 32'h0);
      peek(3'd7, 32'h0, "R11 unused address");

      // mixed traffic checked against the model every clock
      for (int i = 0; i < 2000; i++) begin
         fill_a     = 8'($urandom_range(0, 40));
         fill_b     = 8'($urandom_range(0, 40));
         wakeup_evt = ($urandom_range(0, 15) == 0);
         prot_evt   = ($urandom_range(0, 3) == 0) ? 25'(1 << $urandom_range(0, 24)) : '0;
         herr_evt   = ($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(0, 15)) : '0;
         mb_irq     = 8'($urandom);
         mb_is_tx   = 8'($urandom);
         rd_addr    = 3'($urandom);
         if ($urandom_range(0, 3) == 0) begin
            wr_en = 1'b1; wr_addr = 3'($urandom); wr_data = $urandom;
            if (wr_addr == 3'd5 || wr_addr == 3'd6) wr_data = 32'($urandom_range(0, 40));
         end
         @(posedge clk); #1;
         wr_en = 1'b0;
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule